// File: doc/BRIEF.md
# Four-Level GPU Page Table Walker

This block turns a 48-bit virtual address into a physical address by walking a four-level radix page table held in memory. A walk starts from a table base address, a virtual address and an access kind (read, write or execute). The walker then fetches one 64-bit little-endian entry per level from the memory side, one read at a time, and either descends to the next level, stops early at a large-page leaf, or stops with a fault.

Directory entries at the three upper levels may act as leaves. The page size of such a leaf comes from a fragment field in the entry, capped per level. Every read address is built from a 64-byte-aligned table pointer plus a 9-bit index scaled to 8-byte entries. The read channel may refuse a request. The walker then keeps the refused read parked and offers it again only after the memory side signals a retry.

The result is reported by a one-cycle `done` pulse. It carries the physical address, the page-aligned virtual base, log2 of the page size, the raw entry that ended the walk, and either a fault with its code and present flag or an unsupported-entry error.

Top module: `gpu_pt_walker`

## Requirements
- R1: After synchronous reset the walker is idle: `req_ready`=1, `mem_req_valid`=0, `done`=0. A request is accepted only when `req_valid` and `req_ready` are both high, and `req_ready` stays low until the walk finishes.
- R2: The first read goes to ((base>>6)<<3 + vaddr[47:39])<<3, taken to 48 bits. It is issued as a cacheable read (`mem_req_uncached`=0).
- R3: Levels are visited in the order top, upper-middle, lower-middle, last. Each later read goes to ((entry>>6)<<3 + next 9-bit index)<<3, taken to 48 bits. The index slices are vaddr[38:30], [29:21] and [20:12]. Only one read is outstanding at a time.
- R4: A follow-on read carries `mem_req_uncached`=1 exactly when bit 2 (cacheable) of the entry that pointed to it is 0.
- R5: At the three upper levels, an entry with bit 54 set ends the walk as a leaf. Its log2 size is 12 + min(cap, entry[11:7]), where cap is 27, 18 and 9 for the top, upper-middle and lower-middle levels.
- R6: An entry at the last level always ends the walk with log2 size 12, whatever its bit 54 holds.
- R7: On a leaf, `res_paddr` = (entry[47:12]<<12) + (vaddr mod 2^size) and `res_vbase` = vaddr with its low size bits cleared. `res_entry` holds the leaf entry.
- R8: An entry whose bit 0 (valid) is 0 ends the walk with `res_fault`=1 and `res_present`=0. The code is 0 for read, 1 for write and 2 for execute, with `req_mode` encoded 0=read, 1=write, 2=execute.
- R9: With no-execute enforcement on (the default), an execute walk that meets an entry with bit 4 set faults with code 2 and `res_present`=1. Bit 4 has no effect on read or write walks.
- R10: An entry with a non-zero field in bits [63:59] stops the walk with `res_error`=1 and `res_fault`=0. No further read is issued.
- R11: A read refused by the channel (`mem_req_valid` high while `mem_req_ready` is low) is withdrawn in the next cycle. It is offered again with the same address only after a `mem_retry` pulse.
- R12: `done` is high for exactly one cycle, and the walker is idle in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle, can accept a request |
| req_base | input | 48 | Page-table base address |
| req_vaddr | input | 48 | Virtual address to translate |
| req_mode | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read this cycle |
| mem_req_addr | output | 48 | Byte address of the 8-byte entry |
| mem_req_uncached | output | 1 | Read must bypass caches |
| mem_retry | input | 1 | Memory can take a previously refused read |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Fetched entry, little-endian |
| done | output | 1 | One-cycle end-of-walk pulse |
| res_paddr | output | 48 | Translated physical address |
| res_vbase | output | 48 | Page-aligned virtual base |
| res_log_size | output | 6 | log2 of the page size |
| res_entry | output | 64 | Entry that ended the walk |
| res_fault | output | 1 | Walk ended in a page fault |
| res_fault_code | output | 2 | 0 load, 1 store, 2 instruction |
| res_present | output | 1 | Valid bit of the faulting entry |
| res_error | output | 1 | Unsupported entry encountered |

## Verification
The bench targets early leaves whose fragment lies above, below and exactly at the cap of each level. A design with the wrong cap returns a page size that is too large or too small, and so a wrong physical address. All-ones indices and an unaligned base expose address arithmetic that drops the 64-byte alignment or mis-scales the index, because the first read then lands on the wrong entry. The bench mixes access kinds with invalid and execute-protected entries at different depths. Swapped fault codes or an execute check applied to reads show up as wrong fault flags. It also refuses reads twice in a row, so a walker that resends without waiting for the retry, changes the address or issues a second read is caught on the memory channel.

// File: rtl/ptw_pkg.sv
// ptw_pkg: shared widths, entry bit positions and encodings of the page
// table walker. Assumes a 48-bit address space and 64-bit table entries.
package ptw_pkg;
    localparam int VA_W       = 48;
    localparam int PA_W       = 48;
    localparam int ENT_W      = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 9;
    localparam int LEVELS     = 4;
    localparam int LSZ_W      = 6;
    localparam int FRAG_W     = 5;
    localparam int PPN_W      = PA_W - PAGE_SHIFT;

    // entry field positions
    localparam int B_VALID    = 0;
    localparam int B_CACHE    = 2;
    localparam int B_NOEXEC   = 4;
    localparam int B_FRAG_LO  = 7;
    localparam int B_LEAF     = 54;
    localparam int B_BFS_LO   = 59;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_t;

    typedef enum logic [1:0] {
        FC_LOAD  = 2'd0,
        FC_STORE = 2'd1,
        FC_INSTR = 2'd2
    } fcode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_HOLD,
        ST_WAIT,
        ST_DONE
    } walk_st_t;
endpackage

// File: rtl/ptw_addr_gen.sv
// ptw_addr_gen: forms the byte address of one table entry from a table
// pointer word (low 6 bits ignored) and a 9-bit index of 8-byte entries.
// Assumes the result wraps to the physical address width.
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int AW = PA_W,
    parameter int IW = IDX_W
) (
    input  logic [ENT_W-1:0] tbl_word,
    input  logic [IW-1:0]    idx,
    output logic [AW-1:0]    rd_addr
);
    localparam int ALIGN_SH = 6;
    localparam int ENT_SH   = 3;

    // pointer in entry units plus index, scaled back to bytes
    always_comb begin
        rd_addr = AW'((((tbl_word >> ALIGN_SH) << ENT_SH) + ENT_W'(idx)) << ENT_SH);
    end
endmodule

// File: rtl/ptw_entry_eval.sv
// ptw_entry_eval: classifies a fetched entry at a given level as leaf,
// fault or unsupported, and derives the log2 page size of a leaf.
// Assumes level 0 is the top of the table and LEVELS-1 the last level.
module ptw_entry_eval
    import ptw_pkg::*;
#(
    parameter bit NX_EN = 1'b1
) (
    input  logic              f_valid,
    input  logic              f_noexec,
    input  logic              f_leaf,
    input  logic [FRAG_W-1:0] f_frag,
    input  logic [4:0]        f_bfs,
    input  logic [1:0]        lvl,
    input  logic [1:0]        acc,
    output logic              is_leaf,
    output logic              is_fault,
    output logic              is_unsup,
    output logic [LSZ_W-1:0]  log_size
);
    localparam int LAST    = LEVELS - 1;
    localparam int MAX_LSZ = PAGE_SHIFT + IDX_W * LAST;

    logic [LSZ_W-1:0] cap;
    logic [LSZ_W-1:0] frag_x;

    // per-level clamp on the fragment
    always_comb begin
        cap    = LSZ_W'(IDX_W * (LAST - int'(lvl)));
        frag_x = LSZ_W'(f_frag);
    end

    // leaf, fault and size decisions
    always_comb begin
        is_leaf  = (int'(lvl) == LAST) || f_leaf;
        is_fault = !f_valid || (NX_EN && f_noexec && (acc == ACC_EXEC));
        is_unsup = |f_bfs;
        if (int'(lvl) == LAST)
            log_size = LSZ_W'(PAGE_SHIFT);
        else
            log_size = LSZ_W'(PAGE_SHIFT) + ((frag_x < cap) ? frag_x : cap);
    end

    // R5: no leaf can exceed the top-level size cap
    always_comb begin
        a_r5_size_cap: assert (int'(log_size) <= MAX_LSZ);
    end
endmodule

// File: rtl/ptw_result.sv
// ptw_result: builds the physical address and page-aligned virtual base
// of a leaf from its frame number, the virtual address and the page size.
// Assumes log_size never exceeds the virtual address width.
module ptw_result
    import ptw_pkg::*;
(
    input  logic [PPN_W-1:0] ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LSZ_W-1:0] log_size,
    output logic [PA_W-1:0]  paddr,
    output logic [VA_W-1:0]  vbase
);
    logic [VA_W-1:0] low_mask;

    // offset mask, then combine frame and offset
    always_comb begin
        low_mask = (VA_W'(1) << log_size) - VA_W'(1);
        paddr    = {ppn, {PAGE_SHIFT{1'b0}}} + (vaddr & low_mask);
        vbase    = vaddr & ~low_mask;
    end
endmodule

// File: rtl/gpu_pt_walker.sv
// gpu_pt_walker: sequences a single four-level table walk, one entry read
// at a time, with park-and-retry on a refused read. Assumes the memory side
// answers every accepted read with exactly one response.
module gpu_pt_walker
    import ptw_pkg::*;
#(
    parameter bit NX_ENFORCE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_base,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_mode,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    output logic              mem_req_uncached,
    input  logic              mem_retry,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              done,
    output logic [PA_W-1:0]   res_paddr,
    output logic [VA_W-1:0]   res_vbase,
    output logic [LSZ_W-1:0]  res_log_size,
    output logic [ENT_W-1:0]  res_entry,
    output logic              res_fault,
    output logic [1:0]        res_fault_code,
    output logic              res_present,
    output logic              res_error
);
    walk_st_t         st_q;
    logic [1:0]       lvl_q;
    logic [VA_W-1:0]  va_q;
    logic [1:0]       acc_q;
    logic [PA_W-1:0]  addr_q;
    logic             unc_q;

    logic [1:0]       nxt_lvl;
    logic [ENT_W-1:0] gen_word;
    logic [IDX_W-1:0] gen_idx;
    logic [PA_W-1:0]  gen_addr;
    logic             ev_leaf, ev_fault, ev_unsup;
    logic [LSZ_W-1:0] ev_lsz;
    logic [PA_W-1:0]  leaf_pa;
    logic [VA_W-1:0]  leaf_vb;
    fcode_t           fcode;

    // table pointer and index for the next read
    always_comb begin
        nxt_lvl = lvl_q + 2'd1;
        if (st_q == ST_IDLE) begin
            gen_word = ENT_W'(req_base);
            gen_idx  = req_vaddr[VA_W-1 -: IDX_W];
        end else begin
            gen_word = mem_rsp_data;
            gen_idx  = va_q[PAGE_SHIFT + IDX_W * (LEVELS - 1 - int'(nxt_lvl)) +: IDX_W];
        end
    end

    ptw_addr_gen u_addr (
        .tbl_word (gen_word),
        .idx      (gen_idx),
        .rd_addr  (gen_addr)
    );

    ptw_entry_eval #(.NX_EN(NX_ENFORCE)) u_eval (
        .f_valid  (mem_rsp_data[B_VALID]),
        .f_noexec (mem_rsp_data[B_NOEXEC]),
        .f_leaf   (mem_rsp_data[B_LEAF]),
        .f_frag   (mem_rsp_data[B_FRAG_LO +: FRAG_W]),
        .f_bfs    (mem_rsp_data[B_BFS_LO +: 5]),
        .lvl      (lvl_q),
        .acc      (acc_q),
        .is_leaf  (ev_leaf),
        .is_fault (ev_fault),
        .is_unsup (ev_unsup),
        .log_size (ev_lsz)
    );

    ptw_result u_res (
        .ppn      (mem_rsp_data[PAGE_SHIFT +: PPN_W]),
        .vaddr    (va_q),
        .log_size (ev_lsz),
        .paddr    (leaf_pa),
        .vbase    (leaf_vb)
    );

    // fault code from the access kind
    always_comb begin
        case (acc_q)
            ACC_WRITE: fcode = FC_STORE;
            ACC_EXEC:  fcode = FC_INSTR;
            default:   fcode = FC_LOAD;
        endcase
    end

    // walk sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= ST_IDLE;
            lvl_q          <= '0;
            va_q           <= '0;
            acc_q          <= '0;
            addr_q         <= '0;
            unc_q          <= 1'b0;
            res_paddr      <= '0;
            res_vbase      <= '0;
            res_log_size   <= '0;
            res_entry      <= '0;
            res_fault      <= 1'b0;
            res_fault_code <= '0;
            res_present    <= 1'b0;
            res_error      <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= req_mode;
                    lvl_q  <= '0;
                    addr_q <= gen_addr;
                    unc_q  <= 1'b0;
                    st_q   <= ST_SEND;
                end
                ST_SEND: st_q <= mem_req_ready ? ST_WAIT : ST_HOLD;
                ST_HOLD: if (mem_retry) st_q <= ST_SEND;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (ev_unsup || ev_fault || ev_leaf) begin
                        res_entry      <= mem_rsp_data;
                        res_paddr      <= leaf_pa;
                        res_vbase      <= leaf_vb;
                        res_log_size   <= ev_lsz;
                        res_error      <= ev_unsup;
                        res_fault      <= !ev_unsup && ev_fault;
                        res_fault_code <= fcode;
                        res_present    <= mem_rsp_data[B_VALID];
                        st_q           <= ST_DONE;
                    end else begin
                        addr_q <= gen_addr;
                        unc_q  <= !mem_rsp_data[B_CACHE];
                        lvl_q  <= nxt_lvl;
                        st_q   <= ST_SEND;
                    end
                end
                ST_DONE: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // port views of the sequencer state
    always_comb begin
        req_ready        = (st_q == ST_IDLE);
        mem_req_valid    = (st_q == ST_SEND);
        mem_req_addr     = addr_q;
        mem_req_uncached = unc_q;
        done             = (st_q == ST_DONE);
    end

    // R11: a refused read is withdrawn and its address kept
    a_r11_park_refused: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> !mem_req_valid && $stable(mem_req_addr));

    // R3: no new read right after one is accepted
    a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R12: done is a single-cycle pulse followed by idle
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    // R1: an idle walker issues nothing
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !done);

    // R6: successful last-level walks return the base page size
    a_r6_last_level_size: assert property (@(posedge clk) disable iff (!rst_n)
        done && !res_fault && !res_error && lvl_q == 2'd3 |-> res_log_size == LSZ_W'(PAGE_SHIFT));

    // R10: error and fault are never reported together
    a_r10_error_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(res_fault && res_error));
endmodule

// File: tb/tb_gpu_pt_walker.sv
module tb_gpu_pt_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_base = '0;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_mode = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_req_uncached;
    logic        mem_retry = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done;
    logic [47:0] res_paddr;
    logic [47:0] res_vbase;
    logic [5:0]  res_log_size;
    logic [63:0] res_entry;
    logic        res_fault;
    logic [1:0]  res_fault_code;
    logic        res_present;
    logic        res_error;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpu_pt_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_vaddr(req_vaddr), .req_mode(req_mode),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_uncached(mem_req_uncached),
        .mem_retry(mem_retry), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .res_paddr(res_paddr), .res_vbase(res_vbase),
        .res_log_size(res_log_size), .res_entry(res_entry), .res_fault(res_fault),
        .res_fault_code(res_fault_code), .res_present(res_present), .res_error(res_error)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] mem [logic [47:0]];

    logic [47:0] eq_addr [$];
    logic        eq_unc [$];
    logic        e_fault, e_err, e_present;
    logic [1:0]  e_code;
    logic [47:0] e_paddr, e_vbase;
    int          e_log;
    logic [63:0] e_entry;

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [47:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic int ix(input logic [47:0] va, input int lvl);
        return int'((va >> (39 - 9*lvl)) & 48'h1FF);
    endfunction

    function automatic logic [47:0] tbl(input logic [47:0] base, input int lvl);
        return (lvl == 0) ? (base & ~48'h3F) : 48'h10_0000 * 48'(lvl);
    endfunction

    task automatic put(input logic [47:0] t, input int i, input logic [63:0] v);
        mem[t + 48'(i) * 48'd8] = v;
    endtask

    // directory chain from level 0 down to leaf_lvl; cmask bit l = cacheable at level l
    task automatic chain(input logic [47:0] base, input logic [47:0] va, input int leaf_lvl,
                         input logic [3:0] cmask, input logic [63:0] leaf);
        mem.delete();
        for (int l = 0; l < leaf_lvl; l++)
            put(tbl(base, l), ix(va, l), 64'(tbl(base, l+1)) | 64'h1 | (cmask[l] ? 64'h4 : 64'h0));
        put(tbl(base, leaf_lvl), ix(va, leaf_lvl), leaf);
    endtask

    // behavioural reference walk
    task automatic ref_walk(input logic [47:0] base, input logic [47:0] va, input logic [1:0] mode);
        logic [63:0] a, e, m;
        logic        u;
        logic [63:0] vpn;
        int          cap, f;
        eq_addr.delete();
        eq_unc.delete();
        e_fault = 0; e_err = 0; e_present = 0; e_code = 0;
        vpn = 64'(va) >> 12;
        a = (((64'(base) >> 6) << 3) + (vpn >> 27)) << 3;
        u = 1'b0;
        for (int lvl = 0; lvl < 4; lvl++) begin
            eq_addr.push_back(a[47:0]);
            eq_unc.push_back(u);
            e = rd_mem(a[47:0]);
            e_entry = e;
            if (e[63:59] != 0) begin e_err = 1; return; end
            if (!e[0] || (e[4] && mode == 2'd2)) begin
                e_fault = 1;
                e_present = e[0];
                e_code = (mode == 2'd1) ? 2'd1 : (mode == 2'd2) ? 2'd2 : 2'd0;
                return;
            end
            if (lvl == 3 || e[54]) begin
                cap = 27 - 9*lvl;
                f = int'(e[11:7]);
                e_log = (lvl == 3) ? 12 : 12 + ((f < cap) ? f : cap);
                m = 64'h1 << e_log;
                e_paddr = 48'(((e >> 12) & 64'hF_FFFF_FFFF) * 64'h1000 + (64'(va) % m));
                e_vbase = 48'(64'(va) - (64'(va) % m));
                return;
            end
            a = (((e >> 6) << 3) + ((vpn >> (18 - 9*lvl)) & 64'h1FF)) << 3;
            a = a & 64'hFFFF_FFFF_FFFF;
            u = !e[2];
        end
    endtask

    task automatic run_walk(input logic [47:0] base, input logic [47:0] va, input logic [1:0] mode,
                            input int refuse, input string size_rq, input string name);
        int cyc, nrd;
        bit fin;
        logic [47:0] xa;
        ref_walk(base, va, mode);
        $display("walk %s", name);
        @(negedge clk);
        chk("R1", "ready before request", req_ready, 1);
        req_valid = 1; req_base = base; req_vaddr = va; req_mode = mode;
        @(negedge clk);
        req_valid = 0;
        chk("R1", "ready while busy", req_ready, 0);
        cyc = 0; nrd = 0; fin = 0;
        while (!fin && cyc < 300) begin
            if (done) begin
                fin = 1;
                chk("R3", "reads left over", 64'(eq_addr.size()), 0);
                chk("R10", "error flag", res_error, e_err);
                if (!e_err) begin
                    chk("R8", "fault flag", res_fault, e_fault);
                    if (e_fault) begin
                        chk("R8", "fault code", res_fault_code, e_code);
                        chk("R8", "present flag", res_present, e_present);
                    end else begin
                        chk(size_rq, "log size", res_log_size, 64'(e_log));
                        chk("R7", "paddr", res_paddr, e_paddr);
                        chk("R7", "vbase", res_vbase, e_vbase);
                        chk("R7", "entry", res_entry, e_entry);
                    end
                end
                @(negedge clk);
                chk("R12", "done width", done, 0);
                chk("R12", "idle after done", req_ready, 1);
            end else if (mem_req_valid) begin
                if (refuse > 0) begin
                    refuse--;
                    xa = mem_req_addr;
                    @(negedge clk);
                    chk("R11", "withdrawn after refusal", mem_req_valid, 0);
                    @(negedge clk);
                    chk("R11", "waits for retry", mem_req_valid, 0);
                    mem_retry = 1;
                    @(negedge clk);
                    mem_retry = 0;
                    chk("R11", "reoffered same addr", mem_req_addr, xa);
                end else begin
                    if (eq_addr.size() == 0) begin
                        chk("R3", "unexpected extra read", 1, 0);
                        xa = mem_req_addr;
                    end else begin
                        xa = eq_addr.pop_front();
                        chk(nrd == 0 ? "R2" : "R3", "read address", mem_req_addr, xa);
                        chk("R4", "uncached flag", mem_req_uncached, eq_unc.pop_front());
                    end
                    nrd++;
                    xa = mem_req_addr;
                    mem_req_ready = 1;
                    @(negedge clk);
                    mem_req_ready = 0;
                    chk("R3", "no read while outstanding", mem_req_valid, 0);
                    @(negedge clk);
                    chk("R3", "still no read", mem_req_valid, 0);
                    mem_rsp_data = rd_mem(xa);
                    mem_rsp_valid = 1;
                    @(negedge clk);
                    mem_rsp_valid = 0;
                end
            end else begin
                @(negedge clk);
            end
            cyc++;
        end
        if (!fin) chk("R12", "walk never finished", 0, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] b, v;
        b = 48'h0000_0005_0017;
        repeat (3) @(negedge clk);
        chk("R1", "reset ready", req_ready, 1);
        chk("R1", "reset no read", mem_req_valid, 0);
        chk("R1", "reset no done", done, 0);
        rst_n = 1;

        // R2 R3 R6 R7: full walk, unaligned base
        v = 48'h0123_4567_89AB;
        chain(b, v, 3, 4'hF, 64'h0000_000A_BCDE_0005);
        run_walk(b, v, 2'd0, 0, "R6", "full read walk");

        // R4: all-ones indices, upper-middle level not cacheable
        v = 48'hFFFF_FFFF_F123;
        chain(b, v, 3, 4'b1101, 64'h0000_0012_3456_7005);
        run_walk(b, v, 2'd1, 0, "R6", "write walk uncached");

        // R5: top-level leaf, fragment 31 clamps to 27
        v = 48'h0ABC_DEF0_1234;
        chain(b, v, 0, 4'hF, 64'h0040_0080_0000_0F81);
        run_walk(b, v, 2'd0, 0, "R5", "top leaf clamped");

        // R5: upper-middle leaf, fragment 5 below cap
        v = 48'h1357_9BDF_2468;
        chain(b, v, 1, 4'hF, 64'h0040_0000_1230_0285);
        run_walk(b, v, 2'd0, 0, "R5", "mid leaf frag 5");

        // R5: lower-middle leaf, fragment 20 clamps to 9
        v = 48'h0FED_CBA9_8765;
        chain(b, v, 2, 4'hF, 64'h0040_0000_4560_0A05);
        run_walk(b, v, 2'd1, 0, "R5", "low leaf clamped");

        // R5: top leaf, fragment exactly 27
        v = 48'h7777_1111_2222;
        chain(b, v, 0, 4'hF, 64'h0040_0000_0000_0D85);
        run_walk(b, v, 2'd0, 0, "R5", "top leaf at cap");

        // R8: invalid upper-middle entry on read
        v = 48'h0123_4567_89AB;
        chain(b, v, 1, 4'hF, 64'h0000_0000_0030_0004);
        run_walk(b, v, 2'd0, 0, "R5", "read fault");

        // R8: invalid last-level entry on write
        chain(b, v, 3, 4'hF, 64'h0000_0000_7000_0000);
        run_walk(b, v, 2'd1, 0, "R6", "write fault");

        // R9: execute meets protected directory entry
        chain(b, v, 2, 4'hF, 64'h0000_0000_0030_0015);
        run_walk(b, v, 2'd2, 0, "R5", "exec protected");

        // R9: protected leaf ignored for reads
        chain(b, v, 3, 4'hF, 64'h0000_0000_9999_9015);
        run_walk(b, v, 2'd0, 0, "R6", "read ignores exec bit");

        // R9: execute walk with exec bit clear succeeds
        chain(b, v, 3, 4'hF, 64'h0000_0000_8888_8005);
        run_walk(b, v, 2'd2, 0, "R6", "exec allowed");

        // R10: unsupported block-fragment field at lower-middle level
        chain(b, v, 2, 4'hF, 64'h0800_0000_0030_0005);
        run_walk(b, v, 2'd0, 0, "R5", "unsupported entry");

        // R6: leaf bit at last level has no effect on size
        v = 48'h2468_ACE0_1357;
        chain(b, v, 3, 4'hF, 64'h0040_0000_5555_5F85);
        run_walk(b, v, 2'd0, 0, "R6", "last level leaf bit");

        // R11: two refused reads
        chain(b, v, 3, 4'b1011, 64'h0000_0000_6666_6005);
        run_walk(b, v, 2'd1, 2, "R6", "refused reads");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule